// File: doc/BRIEF.md
# Dual-Protocol Subsystem Bus Slave

This block is the local-side slave port of a small peripheral. An 8-bit microcontroller uses it to reach a 9-bit register map. The same set of pins carries both bus styles. In the Intel style, separate read and write strobes are used. In the Zilog style, a data strobe is qualified by a read/write line. Each style can run with the low address byte multiplexed on the shared data bus, or with that byte on dedicated address pins.

The port works as follows:
- In multiplexed operation, the address is latched on the trailing edge of the address strobe and held until the next strobe.
- The bus strobes are decoded into read and write cycles.
- Each cycle is steered to one of the following: a control register, a write-only clock-programming register, eight read-only UART register mirrors, or a FIFO window that only answers while serial bypass is enabled.
- The UART core and the FIFOs sit outside the block. It sees the UART registers as a 64-bit mirror input. It sees the FIFOs as a data input with a pop pulse and a data output with a push pulse.

All pins are taken as synchronous to `clk`, and registered edges of the strobes mark the start and end of each cycle.

Top module: `ssbus_slave`

## Requirements
- R1: With `mode_sep` low, the address is `{a8, ad_in}` as latched by the address strobe, and `a_lo` is ignored. With `mode_sep` high, the address is `{a8, a_lo}`, and both `as_pin` and any address placed on `ad_in` are ignored.
- R2: In Intel style (`zbus_sel`=0), the latch captures on the falling edge of a high `as_pin` pulse. In Zilog style (`zbus_sel`=1), it captures on the rising edge of a low pulse. The latched address stays in force after `ad_in` is turned around to data.
- R3: Intel style decodes `rd_ds_n`=0 with `wr_rw`=1 as a read, and `rd_ds_n`=1 with `wr_rw`=0 as a write.
- R4: Zilog style treats `rd_ds_n` as an active-low data strobe. While the strobe is low, `wr_rw`=1 marks a read and `wr_rw`=0 marks a write.
- R5: Address 272 is an 8-bit read/write control register shown on `ctrl_q`. Its bit 0 enables serial bypass.
- R6: Address 288 is write-only. The written byte appears on `pgm_q`, and reads of 288 return 0.
- R7: Reads of addresses 304+k (k=0..7) return byte k of `uart_mirror` (bits 8k+7..8k). The byte order is DLL, IER, FCR, LCR, MCR, LSR, MSR, DLM. A write to 304 stores only data bit 5 into `mcr5_q`, and the read of 308 returns the mirror MCR with bit 5 replaced by `mcr5_q`. Writes to 305..311 change nothing.
- R8: When bypass is enabled, a read of 320 returns `tx_data` and gives one `tx_pop` pulse after the strobe ends. A write to 320 gives one `rx_push` pulse with the byte on `rx_data`.
- R9: Reads of unmapped addresses, and reads of 320 with bypass off, return 0 and produce no pulse. Writes to those addresses change no register and produce no pulse.
- R10: `ad_oe` is high only while a decoded read is in progress, and `ad_out` is 0 at all other times.
- R11: After reset, `ctrl_q`, `pgm_q` and `mcr5_q` are 0, and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sep | input | 1 | 0 = multiplexed address/data, 1 = separate address pins |
| zbus_sel | input | 1 | 0 = Intel-style cycles, 1 = Zilog-style cycles |
| as_pin | input | 1 | Address strobe |
| rd_ds_n | input | 1 | Intel read strobe / Zilog data strobe, active low |
| wr_rw | input | 1 | Intel write strobe (active low) / Zilog read-not-write |
| a8 | input | 1 | Address bit 8 |
| a_lo | input | 8 | Low address bits in separate mode |
| ad_in | input | 8 | Shared bus, inbound |
| ad_out | output | 8 | Shared bus, outbound read data |
| ad_oe | output | 1 | Output enable for the shared bus |
| uart_mirror | input | 64 | UART register copies, byte k at address 304+k |
| tx_data | input | 8 | Transmitter FIFO head |
| tx_pop | output | 1 | One-cycle pop of the transmitter FIFO |
| rx_data | output | 8 | Byte pushed to the receiver FIFO |
| rx_push | output | 1 | One-cycle push to the receiver FIFO |
| ctrl_q | output | 8 | Control register |
| pgm_q | output | 8 | Clock-programming register |
| mcr5_q | output | 1 | Stored MCR bit 5 |

## Verification
Two FIFO events can land in the same clock edge: a `tx_pop` from the end of a read of 320, and an `rx_push` from the start of a write to 320. The bench provokes this in Intel style by releasing the read strobe and asserting the write strobe in one pin change. It then checks that each pulse counter advanced by exactly one and that `rx_data` holds the written byte. Around this case, every address is read in all four bus configurations. Those results are compared with a map computed in the bench, which exposes any decode, latch-edge or mode-gating error.

// File: rtl/ssbus_slave.sv
module ssbus_slave #(
  parameter int AW        = 9,
  parameter int DW        = 8,
  parameter int CTRL_ADR  = 272,
  parameter int PGM_ADR   = 288,
  parameter int MIR_ADR   = 304,
  parameter int FIFO_ADR  = 320,
  parameter int MCR_SLOT  = 4,
  parameter int MCR_BIT   = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_sep,
  input  logic           zbus_sel,
  input  logic           as_pin,
  input  logic           rd_ds_n,
  input  logic           wr_rw,
  input  logic           a8,
  input  logic [7:0]     a_lo,
  input  logic [7:0]     ad_in,
  output logic [7:0]     ad_out,
  output logic           ad_oe,
  input  logic [63:0]    uart_mirror,
  input  logic [7:0]     tx_data,
  output logic           tx_pop,
  output logic [7:0]     rx_data,
  output logic           rx_push,
  output logic [7:0]     ctrl_q,
  output logic [7:0]     pgm_q,
  output logic           mcr5_q
);
  localparam int SLOTS = 8;
  localparam int SW    = $clog2(SLOTS);

  logic [AW-1:0] lat, addr;
  logic          as_q, rd_q, wr_q, pop_arm;
  logic          rd_act, wr_act, lat_edge, bypass;
  logic [DW-1:0] rd_data, mir_byte;
  logic [SW-1:0] slot;

  assign rd_act   = !rd_ds_n && wr_rw;
  assign wr_act   = zbus_sel ? (!rd_ds_n && !wr_rw) : (rd_ds_n && !wr_rw);
  assign lat_edge = zbus_sel ? (!as_q && as_pin) : (as_q && !as_pin);
  assign addr     = mode_sep ? {a8, a_lo} : lat;
  assign bypass   = ctrl_q[0];
  assign slot     = addr[SW-1:0];
  assign mir_byte = uart_mirror[slot*DW +: DW];

  wire hit_ctrl = addr == AW'(CTRL_ADR);
  wire hit_pgm  = addr == AW'(PGM_ADR);
  wire hit_mir  = addr[AW-1:SW] == AW'(MIR_ADR) >> SW;
  wire hit_fifo = (addr == AW'(FIFO_ADR)) && bypass;
  wire rd_start = rd_act && !rd_q;
  wire wr_start = wr_act && !wr_q;

  always_comb begin
    rd_data = '0;
    if (hit_ctrl) rd_data = ctrl_q;
    else if (hit_mir) begin
      rd_data = mir_byte;
      if (slot == SW'(MCR_SLOT)) rd_data[MCR_BIT] = mcr5_q;
    end
    else if (hit_fifo) rd_data = tx_data;
  end

  assign ad_oe  = rd_act;
  assign ad_out = rd_act ? rd_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= '0;
      as_q <= 1'b0;
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      as_q <= as_pin;
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (!mode_sep && lat_edge) lat <= {a8, ad_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pgm_q   <= '0;
      mcr5_q  <= 1'b0;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      rx_push <= 1'b0;
      if (wr_start) begin
        if (hit_ctrl) ctrl_q <= ad_in;
        if (hit_pgm)  pgm_q  <= ad_in;
        if (addr == AW'(MIR_ADR)) mcr5_q <= ad_in[MCR_BIT];
        if (hit_fifo) begin
          rx_push <= 1'b1;
          rx_data <= ad_in;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_arm <= 1'b0;
      tx_pop  <= 1'b0;
    end else begin
      tx_pop <= 1'b0;
      if (rd_start) pop_arm <= hit_fifo;
      else if (rd_q && !rd_act) begin
        tx_pop  <= pop_arm;
        pop_arm <= 1'b0;
      end
    end
  end

  AST_POP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> ($past(rd_q) && !$past(rd_act))); // R8
  AST_PUSH_NEEDS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(ctrl_q[0])); // R8
  AST_PGM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pgm_q) |-> $past(wr_act)); // R6
  AST_MCR5_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mcr5_q) |-> $past(wr_act)); // R7
  AST_LATCH_MUX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lat) |-> !$past(mode_sep)); // R1
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ds_n |-> (!ad_oe && ad_out == '0)); // R10
endmodule

// File: tb/ssbus_slave_bench.sv
module ssbus_slave_bench;
  logic clk = 0, rst_n = 0;
  logic mode_sep = 0, zbus_sel = 0, as_pin = 0, rd_ds_n = 1, wr_rw = 1, a8 = 0;
  logic [7:0] a_lo = 0, ad_in = 0, tx_data = 8'hA5;
  logic [63:0] uart_mirror;
  logic [7:0] ad_out, rx_data, ctrl_q, pgm_q;
  logic ad_oe, tx_pop, rx_push, mcr5_q;
  int n_chk = 0, n_fail = 0, pops = 0, pushes = 0;
  logic [7:0] ctrl_m = 0;
  logic mcr5_m = 0;

  always #5 clk = ~clk;

  ssbus_slave u_ssbus_slave (.*);

  initial for (int k = 0; k < 8; k++) uart_mirror[k*8 +: 8] = 8'h11 * (k + 1);

  always @(posedge clk) begin
    if (tx_pop) pops++;
    if (rx_push) pushes++;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(input logic [8:0] a);
    logic [7:0] v;
    v = 0;
    if (a == 272) v = ctrl_m;
    else if (a >= 304 && a <= 311) begin
      v = uart_mirror[(a - 304) * 8 +: 8];
      if (a == 308) v[5] = mcr5_m;
    end else if (a == 320 && ctrl_m[0]) v = tx_data;
    return v;
  endfunction

  task automatic set_cfg(input logic ms, input logic z);
    mode_sep = ms; zbus_sel = z; as_pin = z; rd_ds_n = 1; wr_rw = 1;
    tick(2);
  endtask

  task automatic put_addr(input logic [8:0] a);
    a8 = a[8];
    if (mode_sep) begin
      a_lo = a[7:0]; ad_in = ~a[7:0];
    end else begin
      a_lo = ~a[7:0]; ad_in = a[7:0];
    end
    as_pin = ~zbus_sel; tick();
    as_pin = zbus_sel;  tick();
    ad_in = 8'h00; tick();
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [7:0] d, output logic oe);
    put_addr(a);
    rd_ds_n = 0; wr_rw = 1; tick(2);
    d = ad_out; oe = ad_oe;
    rd_ds_n = 1; tick(3);
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [7:0] d);
    put_addr(a);
    ad_in = d;
    if (zbus_sel) begin rd_ds_n = 0; wr_rw = 0; end
    else begin rd_ds_n = 1; wr_rw = 0; end
    tick(1);
    chk({31'd0, ad_oe}, 0, "R10 oe during write");
    tick(1);
    rd_ds_n = 1; wr_rw = 1; tick(2);
    if (a == 272) ctrl_m = d;
    if (a == 304) mcr5_m = d[5];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int p0, q0;
    tick(3);
    rst_n = 1; tick(2);
    chk(ctrl_q, 0, "R11 ctrl"); chk(pgm_q, 0, "R11 pgm");
    chk(mcr5_q, 0, "R11 mcr5"); chk({tx_pop, rx_push}, 0, "R11 pulses");
    chk({ad_oe, ad_out}, 0, "R10 idle");

    for (int cfg = 0; cfg < 4; cfg++) begin
      set_cfg(cfg[1], cfg[0]);
      p0 = pops;
      for (int a = 0; a < 512; a++) begin
        bus_read(9'(a), d, oe);
        chk(d, exp_rd(9'(a)), "R1 R2 R3 R4 R7 R9 sweep read");
        chk(oe, 1, "R10 oe in read");
      end
      chk(pops, p0, "R9 no pop bypass off");
    end

    set_cfg(0, 0);
    bus_write(272, 8'h5A); chk(ctrl_q, 8'h5A, "R5 ctrl write");
    bus_read(272, d, oe);  chk(d, 8'h5A, "R5 ctrl read");
    bus_write(288, 8'h3C); chk(pgm_q, 8'h3C, "R6 pgm write");
    bus_read(288, d, oe);  chk(d, 0, "R6 pgm read zero");
    set_cfg(0, 1);
    bus_write(304, 8'hFF); chk(mcr5_q, 1, "R7 mcr5 set");
    bus_read(308, d, oe);  chk(d, 8'h75, "R7 mcr read merged");
    bus_write(304, 8'hDF); chk(mcr5_q, 0, "R7 mcr5 clear only bit5");
    set_cfg(1, 1);
    bus_write(304, 8'h20); chk(mcr5_q, 1, "R7 mcr5 sep mode");
    for (int a = 305; a < 312; a++) begin
      bus_write(9'(a), 8'hFF);
      bus_read(9'(a), d, oe);
      chk(d, exp_rd(9'(a)), "R7 readonly write ignored");
    end
    chk({ctrl_q, pgm_q, 7'd0, mcr5_q}, {8'h5A, 8'h3C, 8'h01}, "R9 readonly no side effect");
    q0 = pushes;
    bus_write(320, 8'h77); chk(pushes, q0, "R9 fifo write bypass off");
    bus_write(400, 8'h77); chk({ctrl_q, pgm_q}, {8'h5A, 8'h3C}, "R9 unmapped write");

    for (int cfg = 0; cfg < 4; cfg++) begin
      set_cfg(cfg[1], cfg[0]);
      bus_write(272, 8'h01);
      p0 = pops; q0 = pushes;
      bus_read(320, d, oe);
      chk(d, 8'hA5, "R8 fifo read data");
      chk(pops, p0 + 1, "R8 one pop");
      bus_write(320, 8'h40 + 8'(cfg));
      chk(pushes, q0 + 1, "R8 one push");
      chk(rx_data, 8'h40 + 8'(cfg), "R8 push data");
      chk(pops, p0 + 1, "R8 no pop on write");
      for (int a = 300; a < 330; a++) begin
        bus_read(9'(a), d, oe);
        chk(d, exp_rd(9'(a)), "R8 R9 bypass sweep");
      end
    end

    set_cfg(1, 0);
    p0 = pops; q0 = pushes;
    put_addr(320);
    rd_ds_n = 0; wr_rw = 1; tick(2);
    chk(ad_out, 8'hA5, "R8 overlap read data");
    ad_in = 8'hC3; rd_ds_n = 1; wr_rw = 0; tick(2);
    rd_ds_n = 1; wr_rw = 1; tick(3);
    chk(pops, p0 + 1, "R8 overlap pop");
    chk(pushes, q0 + 1, "R8 overlap push");
    chk(rx_data, 8'hC3, "R8 overlap data");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule